// File: doc/BRIEF.md
# Two-Phase Alternating Pulse Sequencer

This block drives two outputs, A and B, for the switches of a half-bridge. In each cycle A goes high for a programmed number of clock cycles. Then both outputs stay low for a programmed A-to-B gap. B then goes high for its own programmed width, and a programmed B-to-A gap follows before A rises again. Each edge is placed exactly one programmed interval after the previous edge. Wrapping from the end of one cycle to the start of the next adds no extra cycle, so the timing does not drift over many cycles.

An alternative square mode drives A with a 50% duty square wave whose half-period is programmed in clock cycles, and holds B low. All settings are 16-bit clock-cycle counts on plain input ports. The block copies them only when A rises, so no cycle mixes old and new values. A one-clock strobe marks every A rising edge, so the repetition period can be measured at the ports.

Top module: `pulse_pair_seq`

## Requirements
- R1: While `enable` is high in pulse mode, the outputs repeat this order: `outA` high, both low (A-to-B gap), `outB` high, both low (B-to-A gap), then `outA` high again.
- R2: `outA` stays high for exactly `widthA` cycles and `outB` for exactly `widthB` cycles. A width of 0 gives 1 cycle.
- R3: The A-to-B gap lasts exactly `gapAB` cycles and the B-to-A gap exactly `gapBA` cycles. A gap of 0 gives one low cycle.
- R4: `cycleStrobe` is high for exactly one clock, in the first cycle that `outA` is high after being low. The strobe-to-strobe interval equals the sum of the four clamped intervals, with no extra wrap cycle.
- R5: `squareMode`, `widthA`, `gapAB`, `widthB`, `gapBA` and `halfPeriod` are sampled only at the clock edge where `outA` rises. A change at any other time has no effect until the next cycle starts.
- R6: When `enable` is low at a clock edge, both outputs are low after that edge. When `enable` is seen high at an edge while the block is idle, `outA` rises at that same edge and a new cycle begins.
- R7: With `squareMode` = 1 sampled at cycle start, `outA` is high for `halfPeriod` cycles and then low for `halfPeriod` cycles (0 gives 1), and `outB` stays low.
- R8: `outA` and `outB` are never high in the same cycle.
- R9: While `rstN` is low, `outA`, `outB` and `cycleStrobe` are low after each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Run the sequencer; low forces idle |
| squareMode | input | 1 | 1 selects the 50% square wave on A |
| widthA | input | 16 | A high time in cycles |
| gapAB | input | 16 | Low time from A falling to B rising |
| widthB | input | 16 | B high time in cycles |
| gapBA | input | 16 | Low time from B falling to next A rising |
| halfPeriod | input | 16 | Square mode half-period in cycles |
| outA | output | 1 | Pulse output A |
| outB | output | 1 | Pulse output B |
| cycleStrobe | output | 1 | One-clock marker at each A rising edge |

## Verification
A behavioural model tracks the position within the cycle and is compared with the outputs on every clock. It runs with unequal widths and gaps in each direction, with all-zero settings that test the one-cycle clamps, with a 40-cycle pulse, and with long gaps. Unequal intervals show whether the phase order or a gap has been swapped. Zero settings expose missing clamps and the extra wrap cycle. Further runs change the settings in the middle of a cycle, toggle enable quickly, and switch into and out of square mode. These show whether new values take effect early and whether a restart begins with A.

// File: rtl/pulse_seq_pkg.sv
package pulse_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_A_HI   = 3'd1,
    PH_GAP_AB = 3'd2,
    PH_B_HI   = 3'd3,
    PH_GAP_BA = 3'd4
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic   load;      // reload the interval counter for nextPhase
    logic   capture;   // take a fresh copy of the settings (cycle start)
    phase_t nextPhase; // phase in force after this edge
  } seq_ctl_t;

endpackage

// File: rtl/pulse_seq_datapath.sv
module pulse_seq_datapath
  import pulse_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  seq_ctl_t         ctl,
  input  logic             squareMode,
  input  logic [CNT_W-1:0] widthA,
  input  logic [CNT_W-1:0] gapAB,
  input  logic [CNT_W-1:0] widthB,
  input  logic [CNT_W-1:0] gapBA,
  input  logic [CNT_W-1:0] halfPeriod,
  output logic             cntZero,
  output logic             latSq
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] latWA, latGAB, latWB, latGBA, latH;
  logic [CNT_W-1:0] cnt;

  logic             srcSq;
  logic [CNT_W-1:0] srcWA, srcGAB, srcWB, srcGBA, srcH;
  logic [CNT_W-1:0] phaseLen;

  function automatic logic [CNT_W-1:0] clampOne(input logic [CNT_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  // At cycle start the lengths come straight from the inputs
  always_comb begin
    srcSq  = ctl.capture ? squareMode : latSq;
    srcWA  = clampOne(ctl.capture ? widthA     : latWA);
    srcGAB = clampOne(ctl.capture ? gapAB      : latGAB);
    srcWB  = clampOne(ctl.capture ? widthB     : latWB);
    srcGBA = clampOne(ctl.capture ? gapBA      : latGBA);
    srcH   = clampOne(ctl.capture ? halfPeriod : latH);
    case (ctl.nextPhase)
      PH_A_HI:   phaseLen = srcSq ? srcH : srcWA;
      PH_GAP_AB: phaseLen = srcGAB;
      PH_B_HI:   phaseLen = srcWB;
      PH_GAP_BA: phaseLen = srcSq ? srcH : srcGBA;
      default:   phaseLen = ONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latSq  <= 1'b0;
      latWA  <= ONE;
      latGAB <= ONE;
      latWB  <= ONE;
      latGBA <= ONE;
      latH   <= ONE;
    end else if (ctl.capture) begin
      latSq  <= squareMode;
      latWA  <= widthA;
      latGAB <= gapAB;
      latWB  <= widthB;
      latGBA <= gapBA;
      latH   <= halfPeriod;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      cnt <= '0;
    else if (ctl.load)
      cnt <= phaseLen - ONE;
    else if (cnt != '0)
      cnt <= cnt - ONE;
  end

  assign cntZero = (cnt == '0);

  AST_CAPTURE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> ($stable(latWA) && $stable(latWB) && $stable(latSq))) // R5
    else $error("settings changed outside cycle start");

endmodule

// File: rtl/pulse_seq_control.sv
module pulse_seq_control
  import pulse_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     cntZero,
  input  logic     latSq,
  output seq_ctl_t ctl,
  output logic     outA,
  output logic     outB,
  output logic     cycleStrobe
);

  phase_t phase;
  phase_t afterPhase;

  always_comb begin
    case (phase)
      PH_A_HI:   afterPhase = latSq ? PH_GAP_BA : PH_GAP_AB;
      PH_GAP_AB: afterPhase = PH_B_HI;
      PH_B_HI:   afterPhase = PH_GAP_BA;
      default:   afterPhase = PH_A_HI;
    endcase
  end

  always_comb begin
    ctl.load      = 1'b0;
    ctl.capture   = 1'b0;
    ctl.nextPhase = phase;
    if (!enable) begin
      ctl.nextPhase = PH_IDLE;
    end else if (phase == PH_IDLE) begin
      ctl.nextPhase = PH_A_HI;
      ctl.load      = 1'b1;
      ctl.capture   = 1'b1;
    end else if (cntZero) begin
      ctl.nextPhase = afterPhase;
      ctl.load      = 1'b1;
      ctl.capture   = (afterPhase == PH_A_HI);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      cycleStrobe <= 1'b0;
    end else begin
      phase       <= ctl.nextPhase;
      cycleStrobe <= ctl.capture;
    end
  end

  assign outA = (phase == PH_A_HI);
  assign outB = (phase == PH_B_HI);

  AST_SQ_B_LOW: assert property (@(posedge clk) disable iff (!rstN)
    latSq |-> (phase != PH_B_HI)) // R7
    else $error("B driven in square mode");

endmodule

// File: rtl/pulse_pair_seq.sv
module pulse_pair_seq
  import pulse_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             squareMode,
  input  logic [CNT_W-1:0] widthA,
  input  logic [CNT_W-1:0] gapAB,
  input  logic [CNT_W-1:0] widthB,
  input  logic [CNT_W-1:0] gapBA,
  input  logic [CNT_W-1:0] halfPeriod,
  output logic             outA,
  output logic             outB,
  output logic             cycleStrobe
);

  seq_ctl_t ctl;
  logic     cntZero;
  logic     latSq;

  pulse_seq_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .cntZero     (cntZero),
    .latSq       (latSq),
    .ctl         (ctl),
    .outA        (outA),
    .outB        (outB),
    .cycleStrobe (cycleStrobe)
  );

  pulse_seq_datapath #(.CNT_W(CNT_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .squareMode (squareMode),
    .widthA     (widthA),
    .gapAB      (gapAB),
    .widthB     (widthB),
    .gapBA      (gapBA),
    .halfPeriod (halfPeriod),
    .cntZero    (cntZero),
    .latSq      (latSq)
  );

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(outA && outB)) // R8
    else $error("A and B high together");

  AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outA) |-> cycleStrobe) // R4
    else $error("A rose without strobe");

  AST_DISABLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!outA && !outB)) // R6
    else $error("output high after disable");

  AST_GAP_AFTER_A: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outA) |-> !outB) // R3
    else $error("B rose without gap");

endmodule

// File: tb/pulse_pair_seq_test.sv
module pulse_pair_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        squareMode = 1'b0;
  logic [15:0] widthA = 16'd0, gapAB = 16'd0, widthB = 16'd0, gapBA = 16'd0;
  logic [15:0] halfPeriod = 16'd0;
  logic        outA, outB, cycleStrobe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string curReq = "R9";

  always #2 clk = ~clk;

  pulse_pair_seq uut (
    .clk(clk), .rstN(rstN), .enable(enable), .squareMode(squareMode),
    .widthA(widthA), .gapAB(gapAB), .widthB(widthB), .gapBA(gapBA),
    .halfPeriod(halfPeriod), .outA(outA), .outB(outB), .cycleStrobe(cycleStrobe)
  );

  // Behavioural reference: position t within the current cycle
  bit mActive = 0, mSq = 0;
  int mA, mGab, mB, mGba, mH, per = 1, prevPer = 0, t = 0;

  function automatic int cl(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  always @(posedge clk) begin
    if (!rstN || !enable) begin
      mActive = 0;
    end else if (!mActive || t == per - 1) begin
      prevPer = mActive ? per : 0;
      mActive = 1; t = 0;
      mSq = squareMode;
      mA = cl(widthA); mGab = cl(gapAB); mB = cl(widthB); mGba = cl(gapBA);
      mH = cl(halfPeriod);
      per = mSq ? 2 * mH : mA + mGab + mB + mGba;
    end else begin
      t++;
    end
  end

  int cyc = 0, lastStrobe = -1;
  bit lastValid = 0;

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    bit eA, eB, eS;
    if (!done) begin
      cyc++;
      eA = mActive && (mSq ? (t < mH) : (t < mA));
      eB = mActive && !mSq && (t >= mA + mGab) && (t < mA + mGab + mB);
      eS = mActive && (t == 0);
      check(curReq, outA, eA, "outA");
      check(curReq, outB, eB, "outB");
      check(curReq, cycleStrobe, eS, "cycleStrobe");
      if (outA && outB) check("R8", 1, 0, "overlap");
      if (!mActive) lastValid = 0;
      if (eS) begin
        if (lastValid && prevPer != 0) check("R4", cyc - lastStrobe, prevPer, "strobe interval");
        lastStrobe = cyc; lastValid = 1;
      end
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setPulse(input int a, input int gab, input int b, input int gba);
    widthA = 16'(a); gapAB = 16'(gab); widthB = 16'(b); gapBA = 16'(gba);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    curReq = "R9";
    waitCyc(1); enable = 1'b1; setPulse(3, 2, 4, 5);
    waitCyc(4);
    rstN = 1'b1; enable = 1'b0;
    waitCyc(2);
    curReq = "R1"; enable = 1'b1;
    waitCyc(150);
    curReq = "R2"; setPulse(40, 7, 13, 9);
    waitCyc(400);
    curReq = "R3"; setPulse(0, 0, 0, 0);
    waitCyc(40);
    setPulse(2, 0, 1, 6);
    waitCyc(60);
    curReq = "R4"; setPulse(5, 300, 11, 450);
    waitCyc(2400);
    curReq = "R5"; setPulse(6, 3, 8, 4);
    waitCyc(70);
    for (int i = 0; i < 12; i++) begin
      waitCyc(3 + i);
      setPulse(2 + i, 1 + (i % 3), 9 - (i % 5), 2 + i);
    end
    waitCyc(60);
    curReq = "R6";
    for (int i = 0; i < 6; i++) begin
      enable = 1'b0;
      waitCyc(1);
      check("R6", outA | outB, 0, "outputs after disable");
      waitCyc(i);
      enable = 1'b1;
      waitCyc(1);
      check("R6", outA, 1, "A first after enable");
      waitCyc(7 + 3 * i);
    end
    curReq = "R7"; squareMode = 1'b1; halfPeriod = 16'd7;
    waitCyc(120);
    halfPeriod = 16'd0;
    waitCyc(30);
    halfPeriod = 16'd25;
    waitCyc(200);
    squareMode = 1'b0; setPulse(4, 2, 4, 3);
    waitCyc(80);
    curReq = "R8"; setPulse(1, 0, 1, 0);
    waitCyc(50);
    curReq = "R9"; rstN = 1'b0;
    waitCyc(1);
    check("R9", outA | outB | cycleStrobe, 0, "outputs in reset");
    waitCyc(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule